// File: doc/BRIEF.md
# Accumulator and Register IO Datapath

This block is a small processor datapath holding an accumulator, one general register and a registered output bus. Each clock cycle it takes a 4-bit operation code and a data word from the input bus, and updates its three registers according to that code. Sequencing, instruction storage and condition flags sit outside it. The surrounding logic, or a test program, supplies the code stream one operation per cycle.

Each register changes on an exact, small set of codes and holds on all others. That property lets a short program route a value from the input bus through the accumulator or the register to the output. It can therefore exercise the adder on chosen operand pairs, or confirm that each code selects its own distinct result. Reset is asynchronous and active-low. Its release is synchronised internally, so the registers leave reset on the second rising edge after the reset pin goes high.

Top module: `io_accum_core`

## Requirements
- R1: While reset is active, and after it is released, the accumulator, the general register and the output bus are all zero. Reading out the accumulator (code 4) or the register (code 3) returns 0.
- R2: Codes 1 and 6 both load the accumulator with the input bus. The general register and the output bus keep their values.
- R3: Code 2 copies the accumulator into the general register. The accumulator keeps its value.
- R4: Code 5 loads the general register from the input bus. The accumulator keeps its value.
- R5: At the same clock edge, code 3 writes the general register's value to the output bus, and code 4 writes the accumulator's value to it.
- R6: The output bus changes only on codes 3 and 4.
- R7: Code 7 sets the accumulator to the accumulator plus the register, modulo 256. There is no carry out.
- R8: Code 8 sets the accumulator to the bitwise OR of the accumulator and the register. Code 9 sets it to their bitwise AND.
- R9: Code 10 sets the accumulator to its bitwise complement.
- R10: Codes 0 and 11 to 15 change none of the three registers.
- R11: The code sequence 5, 1, 7, 4 on four consecutive cycles, with input words x and then y on the first two, puts (x + y) mod 256 on the output bus after the fourth edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 4 | Operation code for this cycle |
| din_i | input | 8 | Input data bus |
| dout_o | output | 8 | Registered output bus |

## Verification
A code presented before a rising edge takes effect on the accumulator and the register at that same edge. A code 3 or 4 shows on the output bus at that edge. A value reaches the output one edge after the code that moves it there, so the sum in the four-step sequence appears after the fourth edge. The bench drives each code at a falling edge and advances its reference model at the next rising edge. It compares the output at the following falling edge. The internal reset takes two edges to release, so the bench issues no code for several cycles after reset goes high. The accumulator and the register are checked only through readout codes, and every instruction is followed by such readouts.

// File: rtl/io_accum_pkg.sv
package io_accum_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP0   = 4'd0,
    OP_LDI    = 4'd1,
    OP_A2R    = 4'd2,
    OP_OUTR   = 4'd3,
    OP_OUTA   = 4'd4,
    OP_LDR    = 4'd5,
    OP_LDA    = 4'd6,
    OP_ADD    = 4'd7,
    OP_OR     = 4'd8,
    OP_AND    = 4'd9,
    OP_NOT    = 4'd10
  } op_e;

  typedef enum logic [2:0] {
    ASEL_IN  = 3'd0,
    ASEL_ADD = 3'd1,
    ASEL_OR  = 3'd2,
    ASEL_AND = 3'd3,
    ASEL_NOT = 3'd4
  } asel_e;

  typedef struct packed {
    logic  a_en;
    asel_e a_sel;
    logic  r_en;
    logic  r_from_in;
    logic  o_en;
    logic  o_from_a;
  } ctrl_t;

endpackage

// File: rtl/io_accum_rst_sync.sv
module io_accum_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/io_accum_decode.sv
module io_accum_decode
  import io_accum_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);

  always_comb begin
    ctrl_o           = '0;
    ctrl_o.a_sel     = ASEL_IN;
    unique case (op_i)
      OP_LDI, OP_LDA: begin
        ctrl_o.a_en  = 1'b1;
        ctrl_o.a_sel = ASEL_IN;
      end
      OP_A2R: begin
        ctrl_o.r_en      = 1'b1;
        ctrl_o.r_from_in = 1'b0;
      end
      OP_LDR: begin
        ctrl_o.r_en      = 1'b1;
        ctrl_o.r_from_in = 1'b1;
      end
      OP_OUTR: begin
        ctrl_o.o_en     = 1'b1;
        ctrl_o.o_from_a = 1'b0;
      end
      OP_OUTA: begin
        ctrl_o.o_en     = 1'b1;
        ctrl_o.o_from_a = 1'b1;
      end
      OP_ADD: begin
        ctrl_o.a_en  = 1'b1;
        ctrl_o.a_sel = ASEL_ADD;
      end
      OP_OR: begin
        ctrl_o.a_en  = 1'b1;
        ctrl_o.a_sel = ASEL_OR;
      end
      OP_AND: begin
        ctrl_o.a_en  = 1'b1;
        ctrl_o.a_sel = ASEL_AND;
      end
      OP_NOT: begin
        ctrl_o.a_en  = 1'b1;
        ctrl_o.a_sel = ASEL_NOT;
      end
      default: begin
        ctrl_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/io_accum_alu.sv
module io_accum_alu
  import io_accum_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  asel_e         sel_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] r_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] res_o
);

  logic [DW-1:0] sum;
  logic [DW-1:0] or_v;
  logic [DW-1:0] and_v;
  logic [DW-1:0] not_v;

  // wrapping add, carry discarded
  assign sum = a_i + r_i;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign or_v[b]  = a_i[b] | r_i[b];
    assign and_v[b] = a_i[b] & r_i[b];
    assign not_v[b] = ~a_i[b];
  end

  always_comb begin
    unique case (sel_i)
      ASEL_ADD: res_o = sum;
      ASEL_OR:  res_o = or_v;
      ASEL_AND: res_o = and_v;
      ASEL_NOT: res_o = not_v;
      default:  res_o = din_i;
    endcase
  end

endmodule

// File: rtl/io_accum_regs.sv
module io_accum_regs
  import io_accum_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctrl_t         ctrl_i,
  input  logic [DW-1:0] alu_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] r_o,
  output logic [DW-1:0] dout_o
);

  logic [DW-1:0] a_q, a_d;
  logic [DW-1:0] r_q, r_d;
  logic [DW-1:0] o_q, o_d;

  always_comb begin
    a_d = a_q;
    r_d = r_q;
    o_d = o_q;
    if (ctrl_i.a_en) a_d = alu_i;
    if (ctrl_i.r_en) r_d = ctrl_i.r_from_in ? din_i : a_q;
    if (ctrl_i.o_en) o_d = ctrl_i.o_from_a ? a_q : r_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      r_q <= '0;
      o_q <= '0;
    end else begin
      a_q <= a_d;
      r_q <= r_d;
      o_q <= o_d;
    end
  end

  assign a_o    = a_q;
  assign r_o    = r_q;
  assign dout_o = o_q;

endmodule

// File: rtl/io_accum_core.sv
module io_accum_core
  import io_accum_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   din_i,
  output logic [DW-1:0]   dout_o
);

  logic          rst_n_int;
  ctrl_t         ctrl;
  logic [DW-1:0] a_val;
  logic [DW-1:0] r_val;
  logic [DW-1:0] alu_res;

  io_accum_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  io_accum_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  io_accum_alu #(.DW(DW)) u_alu (
    .sel_i (ctrl.a_sel),
    .a_i   (a_val),
    .r_i   (r_val),
    .din_i (din_i),
    .res_o (alu_res)
  );

  io_accum_regs #(.DW(DW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .ctrl_i (ctrl),
    .alu_i  (alu_res),
    .din_i  (din_i),
    .a_o    (a_val),
    .r_o    (r_val),
    .dout_o (dout_o)
  );

endmodule

// File: rtl/io_accum_core_chk.sv
module io_accum_core_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic [3:0]    op_i,
  input logic [DW-1:0] din_i,
  input logic [DW-1:0] a_q,
  input logic [DW-1:0] r_q,
  input logic [DW-1:0] dout_o
);

  logic is_nop;
  assign is_nop = (op_i == 4'd0) || (op_i > 4'd10);

  p_reset_zero_r1: assert property (@(posedge clk_i)
    !rst_n |=> (!rst_n |-> (a_q == '0 && r_q == '0 && dout_o == '0)));

  p_load_a_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (op_i == 4'd1 || op_i == 4'd6) |=> (a_q == $past(din_i) && $stable(r_q)));

  p_copy_r_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (op_i == 4'd2) |=> (r_q == $past(a_q) && $stable(a_q)));

  p_load_r_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (op_i == 4'd5) |=> (r_q == $past(din_i) && $stable(a_q)));

  p_out_r_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (op_i == 4'd3) |=> (dout_o == $past(r_q)));

  p_out_a_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (op_i == 4'd4) |=> (dout_o == $past(a_q)));

  p_out_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(op_i == 4'd3 || op_i == 4'd4) |=> $stable(dout_o));

  p_add_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (op_i == 4'd7) |=> (a_q == DW'($past(a_q) + $past(r_q))));

  p_not_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (op_i == 4'd10) |=> (a_q == ~$past(a_q)));

  p_nop_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    is_nop |=> ($stable(a_q) && $stable(r_q) && $stable(dout_o)));

endmodule

bind io_accum_core io_accum_core_chk #(.DW(DW)) u_chk (
  .clk_i  (clk_i),
  .rst_n  (rst_n_int),
  .op_i   (op_i),
  .din_i  (din_i),
  .a_q    (a_val),
  .r_q    (r_val),
  .dout_o (dout_o)
);

// File: tb/test_io_accum_core.sv
module test_io_accum_core;

  logic       clk;
  logic       rst_n;
  logic [3:0] op;
  logic [7:0] din;
  logic [7:0] dout;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural reference state
  int m_a, m_r, m_o;

  io_accum_core i_io_accum_core (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .op_i   (op),
    .din_i  (din),
    .dout_o (dout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check_out(input string req);
    checks++;
    if (int'(dout) != m_o) begin
      errors++;
      $display("FAIL %s: dout actual=%02h expected=%02h", req, dout, m_o[7:0]);
    end
  endtask

  task automatic step(input int code, input int data, input string req);
    int na, nr, no;
    op  = 4'(code);
    din = 8'(data);
    @(posedge clk);
    na = m_a; nr = m_r; no = m_o;
    case (code)
      1, 6: na = data;
      2:    nr = m_a;
      3:    no = m_r;
      4:    no = m_a;
      5:    nr = data;
      7:    na = (m_a + m_r) % 256;
      8:    na = m_a | m_r;
      9:    na = m_a & m_r;
      10:   na = 255 - m_a;
      default: ;
    endcase
    m_a = na; m_r = nr; m_o = no;
    @(negedge clk);
    check_out(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op    = 4'd0;
    din   = 8'hA5;
    m_a = 0; m_r = 0; m_o = 0;
    repeat (3) @(negedge clk);
    check_out("R1 during reset");
    // codes applied during reset are ignored
    op = 4'd4; din = 8'hFF;
    @(negedge clk);
    op = 4'd0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out("R1 after release");
    step(3, 8'h77, "R1 register zero");
    step(4, 8'h77, "R1 accumulator zero");

    // load accumulator via code 1
    step(1, 8'hC6, "R2 code1 out held");
    step(4, 8'h00, "R2 code1 value");
    step(3, 8'h00, "R2 register unchanged");
    // load register
    step(5, 8'h35, "R4 out held");
    step(4, 8'h00, "R4 accumulator unchanged");
    step(3, 8'h00, "R4 register value");
    // add
    step(7, 8'h11, "R7 out held");
    step(4, 8'h11, "R7 sum");
    // load via code 6
    step(6, 8'h5A, "R2 code6 out held");
    step(4, 8'h00, "R2 code6 value");
    step(3, 8'h00, "R2 code6 register unchanged");
    // OR
    step(8, 8'h00, "R8 out held");
    step(4, 8'h00, "R8 or result");
    // AND
    step(6, 8'hC6, "R2 reload");
    step(9, 8'hFF, "R8 out held");
    step(4, 8'h00, "R8 and result");
    // complement
    step(10, 8'h00, "R9 out held");
    step(4, 8'h00, "R9 complement");
    step(10, 8'h00, "R9 double");
    step(4, 8'h00, "R9 double value");
    // copy A to R
    step(6, 8'hE1, "R2 load");
    step(2, 8'h00, "R3 out held");
    step(3, 8'h00, "R3 register copy");
    step(4, 8'h00, "R3 accumulator unchanged");
    // output hold across non-output codes
    step(6, 8'h0F, "R6 hold on load");
    step(5, 8'h3C, "R6 hold on rload");
    step(7, 8'h00, "R6 hold on add");
    step(4, 8'h00, "R5 accumulator out");
    step(3, 8'h00, "R5 register out");
    // no-operation codes
    step(0, 8'h99, "R10 code0");
    step(11, 8'h99, "R10 code11");
    step(12, 8'h98, "R10 code12");
    step(13, 8'h97, "R10 code13");
    step(14, 8'h96, "R10 code14");
    step(15, 8'h95, "R10 code15");
    step(4, 8'h00, "R10 accumulator kept");
    step(3, 8'h00, "R10 register kept");
    // scanning sequence with wrap
    step(5, 8'h90, "R11 step1");
    step(1, 8'h85, "R11 step2");
    step(7, 8'h00, "R11 step3");
    step(4, 8'h00, "R11 sum on output");
    checks++;
    if (dout != 8'h15) begin
      errors++;
      $display("FAIL R11: actual=%02h expected=15", dout);
    end
    step(5, 8'h01, "R11 second pair");
    step(1, 8'hFF, "R11 second pair");
    step(7, 8'h00, "R7 wrap");
    step(4, 8'h00, "R7 wrap to zero");
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule